// File: doc/BRIEF.md
# Streaming Cell-Averaging CFAR Detector

This block finds targets in one FFT block of power samples as they stream past. Samples move through a delay line that holds a lagging reference window, lagging guard cells, the cell under test (CUT), leading guard cells and a leading reference window. Two running sums, one per reference window, give the noise estimate. The estimate is scaled by a programmable factor and compared against the CUT. Each output beat carries the CUT value, the threshold, the CUT's bin index and a peak flag. A near-range comparator raises an interrupt on the same beat when a peak sits in a bin below a programmed limit.

The input is a valid/ready stream with an end-of-block marker. When that marker is accepted, the block stalls its input and feeds zeros into the delay line until the last real sample has passed the CUT. It then empties the line, so the tail of a block is reported without waiting for the next block. The output is a valid-only stream with an end-of-block marker, and the consumer must take a beat in every cycle that valid is high.

Top module: `cacfar_stream`

## Requirements
- R1: While reset is high and in the first cycle after it, `m_valid` and `near_irq` are 0 and `s_ready` is 1.
- R2: Every accepted input sample produces exactly one output beat, in arrival order. `m_cut` equals that sample, and `m_bin` counts 0, 1, 2 … from the first sample of a block.
- R3: For the CUT at bin k, the lagging sum covers bins k+LAG_GUARD+1 … k+LAG_GUARD+LAG_WIN and the leading sum covers bins k-LEAD_GUARD-LEAD_WIN … k-LEAD_GUARD-1. Any bin outside 0 … block length-1 counts as 0, so no sample carries over from the previous block.
- R4: With `cfg_mode` equal to 0 or 3, the reference value is the lagging sum plus the leading sum.
- R5: With `cfg_mode` equal to 1, the reference value is the larger of the two sums.
- R6: With `cfg_mode` equal to 2, the reference value is the smaller of the two sums.
- R7: `m_thr` equals (reference value × `cfg_scale`) shifted right by `cfg_shift`, computed at full width without truncation.
- R8: `m_peak` is 1 exactly when `m_cut` is strictly greater than `m_thr`.
- R9: After an input beat with `s_last` is accepted, `s_ready` stays low for exactly LAG_WIN+LAG_GUARD+1 cycles and then returns high. All remaining beats of that block appear during this time with no further input.
- R10: `m_last` is 1 on the beat whose bin is FFT_LEN-1, and the next beat after it carries bin 0.
- R11: `near_irq` is 1 exactly on beats where `m_peak` is 1 and `m_bin` is below `cfg_near_bin`. A limit of 0 never fires, and the interrupt is never high without a beat.
- R12: Cycles with `s_valid` low between samples do not change any output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input can accept; low during flush |
| s_data | input | DW | Power sample |
| s_last | input | 1 | Last sample of the block |
| cfg_mode | input | 2 | 0/3 sum, 1 greatest-of, 2 smallest-of |
| cfg_scale | input | SCALE_W | Threshold multiplier |
| cfg_shift | input | SHIFT_W | Threshold right shift |
| cfg_near_bin | input | BIN_W+1 | Interrupt bin limit (exclusive) |
| m_valid | output | 1 | Output beat valid |
| m_cut | output | DW | Cell under test value |
| m_thr | output | TW | Adaptive threshold |
| m_bin | output | BIN_W | Bin index of the CUT |
| m_peak | output | 1 | CUT above threshold |
| m_last | output | 1 | Last bin of the block |
| near_irq | output | 1 | Near-range detection interrupt |

## Verification
A running sum that drifts has no way to correct itself. Once an add or subtract goes wrong, every later threshold in the block is offset by the same amount. This shows on `m_thr` from the next beat on, and it carries into the next block unless the clear after the flush removes it. A delay line shifted by the wrong number of cells during flush shows up in two ways: a short or long stall on `s_ready` right after the marker, or wrong CUT values and missing beats near the end of the block. The scoreboard compares every field of every beat, so each of these faults is caught within a few beats of where it starts.

// File: rtl/cfar_pkg.sv
package cfar_pkg;
  typedef enum logic [1:0] {
    MODE_SUM     = 2'd0,
    MODE_GREATER = 2'd1,
    MODE_SMALLER = 2'd2,
    MODE_SUM_ALT = 2'd3
  } cfar_mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FLUSH = 2'd1,
    ST_CLEAR = 2'd2
  } flush_state_e;
endpackage

// File: rtl/cfar_window_line.sv
module cfar_window_line #(
  parameter int DW         = 16,
  parameter int LAG_WIN    = 8,
  parameter int LAG_GUARD  = 2,
  parameter int LEAD_GUARD = 2,
  parameter int LEAD_WIN   = 8,
  parameter int SUM_W      = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             clr,
  input  logic [DW-1:0]    din,
  input  logic             din_vld,
  output logic [DW-1:0]    cut,
  output logic             cut_vld,
  output logic [SUM_W-1:0] lag_sum,
  output logic [SUM_W-1:0] lead_sum
);
  localparam int CUT_IDX  = LAG_WIN + LAG_GUARD;
  localparam int TOT      = CUT_IDX + 1 + LEAD_GUARD + LEAD_WIN;
  localparam int LAG_OUT  = LAG_WIN - 1;
  localparam int LEAD_IN  = CUT_IDX + LEAD_GUARD;
  localparam int LEAD_OUT = TOT - 1;

  logic [DW-1:0]    cell_q [TOT];
  logic [TOT-1:0]   vld_q;
  logic [SUM_W-1:0] lag_q, lead_q;

  // index 0 holds the newest sample
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < TOT; i++) cell_q[i] <= '0;
      vld_q <= '0;
    end else if (adv) begin
      cell_q[0] <= din;
      for (int i = 1; i < TOT; i++) cell_q[i] <= cell_q[i-1];
      vld_q <= {vld_q[TOT-2:0], din_vld};
    end
  end

  // sliding add/subtract of each reference window
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lag_q  <= '0;
      lead_q <= '0;
    end else if (adv) begin
      lag_q  <= lag_q + SUM_W'(din) - SUM_W'(cell_q[LAG_OUT]);
      lead_q <= lead_q + SUM_W'(cell_q[LEAD_IN]) - SUM_W'(cell_q[LEAD_OUT]);
    end
  end

  assign cut      = cell_q[CUT_IDX];
  assign cut_vld  = vld_q[CUT_IDX];
  assign lag_sum  = lag_q;
  assign lead_sum = lead_q;

  // R3: sums only move when the line advances
  a_r3_sums_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> ($stable(lag_q) && $stable(lead_q)));
  // R3: the clear after flush leaves an empty line for the next block
  a_r3_clear_empty: assert property (@(posedge clk) disable iff (rst)
    clr |=> (lag_q == '0 && lead_q == '0 && !cut_vld));
endmodule

// File: rtl/cfar_flush_ctrl.sv
module cfar_flush_ctrl
  import cfar_pkg::*;
#(
  parameter int FLUSH_N = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic adv,
  output logic inject,
  output logic clr
);
  localparam int CNT_W = $clog2(FLUSH_N + 1);

  flush_state_e st_q;
  logic [CNT_W-1:0] cnt_q;
  logic fire;

  assign in_ready = (st_q == ST_RUN);
  assign fire     = in_valid && in_ready;
  assign inject   = (st_q == ST_FLUSH);
  assign adv      = fire || inject;
  assign clr      = (st_q == ST_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_RUN: if (fire && in_last) begin
          st_q  <= ST_FLUSH;
          cnt_q <= '0;
        end
        ST_FLUSH: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(FLUSH_N - 1)) st_q <= ST_CLEAR;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  // R9: the marker stalls the input on the very next cycle
  a_r9_stall_after_last: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);
  // R9: input reopens right after the clear cycle
  a_r9_reopen: assert property (@(posedge clk) disable iff (rst)
    clr |=> in_ready);
endmodule

// File: rtl/cfar_threshold.sv
module cfar_threshold
  import cfar_pkg::*;
#(
  parameter int SUM_W   = 21,
  parameter int SCALE_W = 8,
  parameter int SHIFT_W = 4,
  parameter int TW      = 29
) (
  input  logic [SUM_W-1:0]   lag_sum,
  input  logic [SUM_W-1:0]   lead_sum,
  input  logic [1:0]         mode,
  input  logic [SCALE_W-1:0] scale,
  input  logic [SHIFT_W-1:0] shift,
  output logic [TW-1:0]      thr
);
  logic [SUM_W-1:0] ref_val;
  logic [TW-1:0]    prod;

  always_comb begin
    case (cfar_mode_e'(mode))
      MODE_GREATER: ref_val = (lag_sum > lead_sum) ? lag_sum : lead_sum;
      MODE_SMALLER: ref_val = (lag_sum < lead_sum) ? lag_sum : lead_sum;
      default:      ref_val = lag_sum + lead_sum;
    endcase
    prod = TW'(ref_val) * TW'(scale);
    thr  = prod >> shift;
  end
endmodule

// File: rtl/cacfar_stream.sv
module cacfar_stream
  import cfar_pkg::*;
#(
  parameter int DW         = 16,
  parameter int LAG_WIN    = 8,
  parameter int LAG_GUARD  = 2,
  parameter int LEAD_GUARD = 2,
  parameter int LEAD_WIN   = 8,
  parameter int FFT_LEN    = 32,
  parameter int SCALE_W    = 8,
  parameter int SHIFT_W    = 4,
  localparam int BIN_W     = $clog2(FFT_LEN),
  localparam int SUM_W     = DW + $clog2(LAG_WIN + LEAD_WIN + 1),
  localparam int TW        = SUM_W + SCALE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [DW-1:0]      s_data,
  input  logic               s_last,
  input  logic [1:0]         cfg_mode,
  input  logic [SCALE_W-1:0] cfg_scale,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [BIN_W:0]     cfg_near_bin,
  output logic               m_valid,
  output logic [DW-1:0]      m_cut,
  output logic [TW-1:0]      m_thr,
  output logic [BIN_W-1:0]   m_bin,
  output logic               m_peak,
  output logic               m_last,
  output logic               near_irq
);
  localparam int FLUSH_N = LAG_WIN + LAG_GUARD;

  logic adv, inject, clr, adv_d;
  logic [DW-1:0]    line_in, cut;
  logic             cut_vld;
  logic [SUM_W-1:0] lag_sum, lead_sum;
  logic [TW-1:0]    thr;
  logic [BIN_W-1:0] bin_q;
  logic             beat, peak_now, bin_end;

  cfar_flush_ctrl #(.FLUSH_N(FLUSH_N)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(s_valid), .in_last(s_last),
    .in_ready(s_ready), .adv(adv), .inject(inject), .clr(clr)
  );

  assign line_in = inject ? '0 : s_data;

  cfar_window_line #(
    .DW(DW), .LAG_WIN(LAG_WIN), .LAG_GUARD(LAG_GUARD),
    .LEAD_GUARD(LEAD_GUARD), .LEAD_WIN(LEAD_WIN), .SUM_W(SUM_W)
  ) u_line (
    .clk(clk), .rst(rst), .adv(adv), .clr(clr), .din(line_in),
    .din_vld(!inject), .cut(cut), .cut_vld(cut_vld),
    .lag_sum(lag_sum), .lead_sum(lead_sum)
  );

  cfar_threshold #(
    .SUM_W(SUM_W), .SCALE_W(SCALE_W), .SHIFT_W(SHIFT_W), .TW(TW)
  ) u_thr (
    .lag_sum(lag_sum), .lead_sum(lead_sum), .mode(cfg_mode),
    .scale(cfg_scale), .shift(cfg_shift), .thr(thr)
  );

  // one decision per advance, taken the cycle after the line moved
  assign beat     = adv_d && cut_vld;
  assign peak_now = TW'(cut) > thr;
  assign bin_end  = (bin_q == BIN_W'(FFT_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      adv_d    <= 1'b0;
      bin_q    <= '0;
      m_valid  <= 1'b0;
      m_cut    <= '0;
      m_thr    <= '0;
      m_bin    <= '0;
      m_peak   <= 1'b0;
      m_last   <= 1'b0;
      near_irq <= 1'b0;
    end else begin
      adv_d    <= adv;
      m_valid  <= beat;
      near_irq <= beat && peak_now && ({1'b0, bin_q} < cfg_near_bin);
      if (beat) begin
        m_cut  <= cut;
        m_thr  <= thr;
        m_bin  <= bin_q;
        m_peak <= peak_now;
        m_last <= bin_end;
        bin_q  <= bin_end ? '0 : bin_q + 1'b1;
      end
    end
  end

  // R11: interrupt only rides on a detected beat
  a_r11_irq_on_peak: assert property (@(posedge clk) disable iff (rst)
    near_irq |-> (m_valid && m_peak));
  // R10: end marker sits on the final bin
  a_r10_last_bin: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_last) |-> (m_bin == BIN_W'(FFT_LEN - 1)));
  // R8: a flagged beat has CUT above the threshold
  a_r8_peak_above: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_peak) |-> (TW'(m_cut) > m_thr));
  // R9: no output is produced while the block is being cleared
  a_r9_no_beat_after_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> ##1 !m_valid);
endmodule

// File: tb/sim_cacfar_stream.sv
module sim_cacfar_stream;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, LAG_WIN = 8, LAG_GUARD = 2, LEAD_GUARD = 2, LEAD_WIN = 8;
  localparam int FFT_LEN = 32, SCALE_W = 8, SHIFT_W = 4;
  localparam int BIN_W = $clog2(FFT_LEN);
  localparam int SUM_W = DW + $clog2(LAG_WIN + LEAD_WIN + 1);
  localparam int TW = SUM_W + SCALE_W;
  localparam int FLUSH_N = LAG_WIN + LAG_GUARD;

  logic clk = 1'b0, rst = 1'b1;
  logic s_valid = 1'b0, s_ready, s_last = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic [1:0] cfg_mode = '0;
  logic [SCALE_W-1:0] cfg_scale = '0;
  logic [SHIFT_W-1:0] cfg_shift = '0;
  logic [BIN_W:0] cfg_near_bin = '0;
  logic m_valid, m_peak, m_last, near_irq;
  logic [DW-1:0] m_cut;
  logic [TW-1:0] m_thr;
  logic [BIN_W-1:0] m_bin;

  typedef struct {
    longint cut; longint thr; int bin;
    bit peak; bit last; bit irq; string ttag; string ctag;
  } exp_t;
  exp_t q[$];
  longint samp [FFT_LEN];
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cacfar_stream #(
    .DW(DW), .LAG_WIN(LAG_WIN), .LAG_GUARD(LAG_GUARD), .LEAD_GUARD(LEAD_GUARD),
    .LEAD_WIN(LEAD_WIN), .FFT_LEN(FFT_LEN), .SCALE_W(SCALE_W), .SHIFT_W(SHIFT_W)
  ) u0 (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .cfg_mode(cfg_mode), .cfg_scale(cfg_scale), .cfg_shift(cfg_shift),
    .cfg_near_bin(cfg_near_bin), .m_valid(m_valid), .m_cut(m_cut), .m_thr(m_thr),
    .m_bin(m_bin), .m_peak(m_peak), .m_last(m_last), .near_irq(near_irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // fill one block and push its expected beats (R3..R8, R10, R11)
  task automatic build_block(input int blk, input int mode, input int scale,
                             input int shift, input int lim, input string ctag);
    for (int i = 0; i < FFT_LEN; i++) begin
      samp[i] = longint'((i * 37 + blk * 53) % 29 + 10);
      if ((i + blk) % 7 == 3) samp[i] = 300 + i * 5;
      if (blk == 3 && i % 11 == 5) samp[i] = 65535;
    end
    for (int k = 0; k < FFT_LEN; k++) begin
      longint lag = 0, lead = 0, sel;
      exp_t e;
      for (int j = 1; j <= LAG_WIN; j++)
        if (k + LAG_GUARD + j < FFT_LEN) lag += samp[k + LAG_GUARD + j];
      for (int j = 1; j <= LEAD_WIN; j++)
        if (k - LEAD_GUARD - j >= 0) lead += samp[k - LEAD_GUARD - j];
      if (mode == 1) begin sel = (lag > lead) ? lag : lead; e.ttag = "R3 R5 R7"; end
      else if (mode == 2) begin sel = (lag < lead) ? lag : lead; e.ttag = "R3 R6 R7"; end
      else begin sel = lag + lead; e.ttag = "R3 R4 R7"; end
      e.cut  = samp[k];
      e.thr  = (sel * scale) >>> shift;
      e.bin  = k;
      e.peak = samp[k] > e.thr;
      e.last = (k == FFT_LEN - 1);
      e.irq  = e.peak && (k < lim);
      e.ctag = ctag;
      q.push_back(e);
    end
  endtask

  task automatic send(input longint d, input bit l);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = DW'(d); s_last = l;
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic run_block(input int blk, input int mode, input int scale,
                           input int shift, input int lim, input bit gaps);
    int stall;
    cfg_mode = 2'(mode); cfg_scale = SCALE_W'(scale);
    cfg_shift = SHIFT_W'(shift); cfg_near_bin = (BIN_W+1)'(lim);
    build_block(blk, mode, scale, shift, lim, gaps ? "R2 R12" : "R2");
    for (int i = 0; i < FFT_LEN; i++) begin
      send(samp[i], i == FFT_LEN - 1);
      if (gaps && i % 5 == 2) repeat (2) @(negedge clk);
    end
    stall = 0;
    while (!s_ready && stall < 1000) begin stall++; @(negedge clk); end
    chk(stall == FLUSH_N + 1, "R9", "ready low cycles after last", stall, FLUSH_N + 1);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9", "beats still pending after flush", q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (m_valid) begin
        if (q.size() == 0) chk(1'b0, "R2", "unexpected beat bin", longint'(m_bin), -1);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(longint'(m_cut) == e.cut, e.ctag, "cut value", longint'(m_cut), e.cut);
          chk(int'(m_bin) == e.bin, e.ctag, "bin index", longint'(m_bin), e.bin);
          chk(longint'(m_thr) == e.thr, e.ttag, "threshold", longint'(m_thr), e.thr);
          chk(m_peak == e.peak, "R8", "peak flag", longint'(m_peak), longint'(e.peak));
          chk(m_last == e.last, "R10", "last flag", longint'(m_last), longint'(e.last));
          chk(near_irq == e.irq, "R11", "near interrupt", longint'(near_irq), longint'(e.irq));
        end
      end else if (near_irq) begin
        chk(1'b0, "R11", "interrupt without beat", 1, 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    chk(1'b0, "R9", "watchdog expired, run hung", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk(!m_valid, "R1", "m_valid in reset", longint'(m_valid), 0);
    chk(!near_irq, "R1", "near_irq in reset", longint'(near_irq), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!m_valid, "R1", "m_valid after reset", longint'(m_valid), 0);
    chk(!near_irq, "R1", "near_irq after reset", longint'(near_irq), 0);
    chk(s_ready, "R1", "s_ready after reset", longint'(s_ready), 1);
    run_block(1, 0, 1, 4, 10, 1'b0);          // sum, near limit 10
    run_block(2, 1, 1, 3, 0, 1'b1);           // greatest-of, stalls, irq off
    run_block(3, 2, 255, 7, FFT_LEN, 1'b0);   // smallest-of, full-scale samples
    run_block(4, 3, 255, 0, FFT_LEN, 1'b0);   // code 3 as sum, no peaks
    run_block(5, 2, 3, 3, 20, 1'b1);          // smallest-of, stalls, partial limit
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule